// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block sequences the raster timing of a parallel RGB TFT panel. Software loads four 32-bit configuration words through a simple write port while the block is disabled. Raising the enable input then starts a free-running pixel clock strobe. From that strobe the block derives horizontal sync, vertical sync and a data-enable strobe. It also supplies zero-based column and row coordinates of the active area, which a downstream pixel fetch stage uses.

Geometry fields are stored in a compact encoding. The active width is counted in groups of 16 pixels. Horizontal lengths and the vertical sync and active lengths are stored minus one. The vertical porches are stored as raw line counts. A selectable frame phase raises a one-cycle interrupt pulse and sets a sticky status flag. Each timing output has its own polarity bit. The pixel clock divisor is split across two fields of one word, and a bypass bit overrides it.

Top module: `rasterGen`

## Requirements
- R1: After reset every output is 0, pixClkEn is idle and vcmpStatus is clear.
- R2: With the bypass bit clear, pixClkEn is high for one cycle in every PCD+2 clock cycles. PCD is the 10-bit value {word2[31:27], word2[4:0]}.
- R3: With bit 26 of word 2 set, pixClkEn is high on every cycle and both divisor fields are ignored.
- R4: A line has four parts in this order: sync for word0[15:8]+1 ticks, back porch for word0[31:24]+1 ticks, active for (word0[7:2]+1)*16 ticks, front porch for word0[23:16]+1 ticks. The outputs for tick n appear in the clock cycle after pixClkEn is high for tick n, and they change at no other time while enabled.
- R5: A frame has four parts in this order, counted in lines: sync for word1[15:10]+1 lines, back porch for word1[31:24] lines, active for word1[9:0]+1 lines, front porch for word1[23:16] lines. A porch value of 0 gives no porch lines.
- R6: Data enable is active only when both the line position and the frame position are in their active parts. pixX and lineY then give the zero-based active column and row. Both are 0 outside the active region.
- R7: Word 2 holds four polarity bits. Bit 11 inverts vertical sync, bit 12 inverts horizontal sync, bit 13 inverts panelClk and bit 14 inverts data enable. panelClk equals pixClkEn XOR bit 13. The inactive level of each output is its polarity bit.
- R8: word3[1:0] selects the frame phase for the interrupt: 0 = sync start, 1 = back porch start, 2 = active start, 3 = front porch start. With a zero front porch, phase 3 coincides with sync start. vcmpPulse is high for exactly one clock cycle, in the output cycle of the first pixel of the selected line.
- R9: vcmpStatus sets together with vcmpPulse and stays set, while disabled as well, until a write to word 3 with bit 8 = 1 clears it.
- R10: While enable is low, every output is at its inactive level from the next cycle on: pixClkEn low, coordinates 0, no pulse. Enabling again restarts from the first pixel of the frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the timing when high |
| wrEn | input | 1 | Configuration write strobe |
| wrAddr | input | 2 | Word select: 0 line geometry, 1 frame geometry, 2 clock/polarity, 3 interrupt control |
| wrData | input | 32 | Write data |
| pixClkEn | output | 1 | One-cycle pixel clock strobe |
| panelClk | output | 1 | Panel clock level, polarity applied |
| hsyncOut | output | 1 | Horizontal sync, polarity applied |
| vsyncOut | output | 1 | Vertical sync, polarity applied |
| dataEnOut | output | 1 | Data enable, polarity applied |
| pixX | output | 10 | Active column, 0 outside the active area |
| lineY | output | 10 | Active row, 0 outside the active area |
| vcmpPulse | output | 1 | Frame-phase interrupt pulse |
| vcmpStatus | output | 1 | Sticky interrupt flag |

## Verification
The scoreboard runs four configurations. Each one separates an effect that the others could hide. A plain divided setup with non-zero porches checks the order of the line parts and the frame parts. A bypassed, fully inverted setup with zero vertical porches shows that the divisor is ignored, that every polarity bit works, and that the front-porch interrupt folds onto sync. A split divisor with both halves non-zero catches a swapped or dropped high field. A fourth setup selects the active-start phase. The sticky flag and the idle levels are checked while the block is disabled between runs.

// File: rtl/rasterPkg.sv
package rasterPkg;
  localparam int PCD_W   = 10;
  localparam int H_W     = 11;
  localparam int V_W     = 11;
  localparam int COORD_W = 10;

  typedef struct packed {
    logic [5:0]       pplF;
    logic [7:0]       hswF;
    logic [7:0]       hfpF;
    logic [7:0]       hbpF;
    logic [9:0]       lppF;
    logic [5:0]       vswF;
    logic [7:0]       vfpF;
    logic [7:0]       vbpF;
    logic             invV;
    logic             invH;
    logic             invClk;
    logic             invDe;
    logic             bypass;
    logic [PCD_W-1:0] pcd;
    logic [1:0]       vcmpSel;
  } rasterCfg_t;

  typedef struct packed {
    logic               tickNext;
    logic               adv;
    logic               hsAct;
    logic               vsAct;
    logic               deAct;
    logic               vcmpHit;
    logic [COORD_W-1:0] x;
    logic [COORD_W-1:0] y;
  } rasterStrobe_t;
endpackage

// File: rtl/rasterRegs.sv
module rasterRegs
  import rasterPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [31:0] wrData,
  output rasterCfg_t  cfg,
  output logic        clrStatus
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        2'd0: begin
          cfg.pplF <= wrData[7:2];
          cfg.hswF <= wrData[15:8];
          cfg.hfpF <= wrData[23:16];
          cfg.hbpF <= wrData[31:24];
        end
        2'd1: begin
          cfg.lppF <= wrData[9:0];
          cfg.vswF <= wrData[15:10];
          cfg.vfpF <= wrData[23:16];
          cfg.vbpF <= wrData[31:24];
        end
        2'd2: begin
          cfg.pcd    <= {wrData[31:27], wrData[4:0]};
          cfg.invV   <= wrData[11];
          cfg.invH   <= wrData[12];
          cfg.invClk <= wrData[13];
          cfg.invDe  <= wrData[14];
          cfg.bypass <= wrData[26];
        end
        default: cfg.vcmpSel <= wrData[1:0];
      endcase
    end
  end

  assign clrStatus = wrEn && (wrAddr == 2'd3) && wrData[8];
endmodule

// File: rtl/rasterCtrl.sv
module rasterCtrl
  import rasterPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  rasterCfg_t    cfg,
  output logic          tickQ,
  output rasterStrobe_t st
);
  logic [PCD_W:0] divCnt, pcdLim;
  logic [H_W-1:0] hCnt, hsLen, hActStart, hActEnd, hTotal;
  logic [V_W-1:0] vCnt, vsLen, vActStart, vActEnd, vTotal, vTarget;
  logic           hAct, vAct;

  assign pcdLim = (PCD_W+1)'(cfg.pcd) + (PCD_W+1)'(1);
  assign st.tickNext = enable && (cfg.bypass || (divCnt == pcdLim));
  assign st.adv = tickQ && enable;

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      divCnt <= '0;
      tickQ  <= 1'b0;
    end else begin
      tickQ  <= st.tickNext;
      divCnt <= st.tickNext ? '0 : divCnt + (PCD_W+1)'(1);
    end
  end

  assign hsLen     = H_W'(cfg.hswF) + H_W'(1);
  assign hActStart = hsLen + H_W'(cfg.hbpF) + H_W'(1);
  assign hActEnd   = hActStart + H_W'({cfg.pplF, 4'b0000}) + H_W'(16);
  assign hTotal    = hActEnd + H_W'(cfg.hfpF) + H_W'(1);

  assign vsLen     = V_W'(cfg.vswF) + V_W'(1);
  assign vActStart = vsLen + V_W'(cfg.vbpF);
  assign vActEnd   = vActStart + V_W'(cfg.lppF) + V_W'(1);
  assign vTotal    = vActEnd + V_W'(cfg.vfpF);

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (st.adv) begin
      if (hCnt == hTotal - H_W'(1)) begin
        hCnt <= '0;
        vCnt <= (vCnt == vTotal - V_W'(1)) ? '0 : vCnt + V_W'(1);
      end else begin
        hCnt <= hCnt + H_W'(1);
      end
    end
  end

  always_comb begin
    case (cfg.vcmpSel)
      2'd0:    vTarget = '0;
      2'd1:    vTarget = vsLen;
      2'd2:    vTarget = vActStart;
      default: vTarget = (cfg.vfpF == 8'd0) ? '0 : vActEnd;
    endcase
  end

  assign hAct       = (hCnt >= hActStart) && (hCnt < hActEnd);
  assign vAct       = (vCnt >= vActStart) && (vCnt < vActEnd);
  assign st.hsAct   = hCnt < hsLen;
  assign st.vsAct   = vCnt < vsLen;
  assign st.deAct   = hAct && vAct;
  assign st.vcmpHit = (hCnt == '0) && (vCnt == vTarget);
  assign st.x       = st.deAct ? COORD_W'(hCnt - hActStart) : '0;
  assign st.y       = st.deAct ? COORD_W'(vCnt - vActStart) : '0;
endmodule

// File: rtl/rasterOut.sv
module rasterOut
  import rasterPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  rasterCfg_t         cfg,
  input  rasterStrobe_t      st,
  input  logic               clrStatus,
  output logic               panelClk,
  output logic               hsyncOut,
  output logic               vsyncOut,
  output logic               dataEnOut,
  output logic [COORD_W-1:0] pixX,
  output logic [COORD_W-1:0] lineY,
  output logic               vcmpPulse,
  output logic               vcmpStatus
);
  logic setStatus;
  assign setStatus = st.adv && st.vcmpHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      panelClk  <= 1'b0;
      hsyncOut  <= 1'b0;
      vsyncOut  <= 1'b0;
      dataEnOut <= 1'b0;
      pixX      <= '0;
      lineY     <= '0;
      vcmpPulse <= 1'b0;
    end else if (!enable) begin
      panelClk  <= cfg.invClk;
      hsyncOut  <= cfg.invH;
      vsyncOut  <= cfg.invV;
      dataEnOut <= cfg.invDe;
      pixX      <= '0;
      lineY     <= '0;
      vcmpPulse <= 1'b0;
    end else begin
      panelClk  <= st.tickNext ^ cfg.invClk;
      vcmpPulse <= setStatus;
      if (st.adv) begin
        hsyncOut  <= st.hsAct ^ cfg.invH;
        vsyncOut  <= st.vsAct ^ cfg.invV;
        dataEnOut <= st.deAct ^ cfg.invDe;
        pixX      <= st.x;
        lineY     <= st.y;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) vcmpStatus <= 1'b0;
    else       vcmpStatus <= (vcmpStatus && !clrStatus) || setStatus;
  end
endmodule

// File: rtl/rasterGen.sv
module rasterGen
  import rasterPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [31:0] wrData,
  output logic        pixClkEn,
  output logic        panelClk,
  output logic        hsyncOut,
  output logic        vsyncOut,
  output logic        dataEnOut,
  output logic [9:0]  pixX,
  output logic [9:0]  lineY,
  output logic        vcmpPulse,
  output logic        vcmpStatus
);
  rasterCfg_t    cfg;
  rasterStrobe_t st;
  logic          clrStatus;

  rasterRegs u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cfg(cfg), .clrStatus(clrStatus)
  );

  rasterCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .cfg(cfg),
    .tickQ(pixClkEn), .st(st)
  );

  rasterOut u_out (
    .clk(clk), .rstN(rstN), .enable(enable), .cfg(cfg), .st(st),
    .clrStatus(clrStatus), .panelClk(panelClk), .hsyncOut(hsyncOut),
    .vsyncOut(vsyncOut), .dataEnOut(dataEnOut), .pixX(pixX), .lineY(lineY),
    .vcmpPulse(vcmpPulse), .vcmpStatus(vcmpStatus)
  );
endmodule

// File: rtl/rasterGenChk.sv
module rasterGenChk (
  input logic        clk,
  input logic        rstN,
  input logic        enable,
  input logic        wrEn,
  input logic [1:0]  wrAddr,
  input logic [31:0] wrData,
  input logic        pixClkEn,
  input logic        hsyncOut,
  input logic        vsyncOut,
  input logic        dataEnOut,
  input logic [9:0]  pixX,
  input logic [9:0]  lineY,
  input logic        vcmpPulse,
  input logic        vcmpStatus
);
  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!pixClkEn && !vcmpPulse && pixX == '0 && lineY == '0));

  a_r8_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rstN)
    vcmpPulse |=> !vcmpPulse);

  a_r9_set_with_pulse: assert property (@(posedge clk) disable iff (!rstN)
    vcmpPulse |-> vcmpStatus);

  a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    (vcmpStatus && !(wrEn && wrAddr == 2'd3 && wrData[8])) |=> vcmpStatus);

  a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !$past(pixClkEn)) |->
      ($stable(hsyncOut) && $stable(vsyncOut) && $stable(dataEnOut) &&
       $stable(pixX) && $stable(lineY)));
endmodule

bind rasterGen rasterGenChk u_chk (.*);

// File: tb/rasterGen_bench.sv
module rasterGen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        pixClkEn, panelClk, hsyncOut, vsyncOut, dataEnOut;
  logic [9:0]  pixX, lineY;
  logic        vcmpPulse, vcmpStatus;

  rasterGen u_rasterGen (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int hswF, hbpF, hfpF, pplF, lppF, vswF, vbpF, vfpF, pcd, sel;
  bit invV, invH, invC, invD, byp;

  int mh, mv;
  logic [23:0] expQ[$];
  bit monOn = 0;
  bit pend = 0;
  int cyc = 0;
  int lastTick = -1;
  int tickCnt = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver side: model the next tick from the requirements and queue it
  task automatic pushExpected();
    int hsL, hA0, hA1, hT, vsL, vA0, vA1, vT, tgt;
    bit hs, vs, de, vp;
    int x, y;
    hsL = hswF + 1; hA0 = hsL + hbpF + 1; hA1 = hA0 + (pplF + 1) * 16;
    hT = hA1 + hfpF + 1;
    vsL = vswF + 1; vA0 = vsL + vbpF; vA1 = vA0 + lppF + 1; vT = vA1 + vfpF;
    case (sel)
      0: tgt = 0;
      1: tgt = vsL;
      2: tgt = vA0;
      default: tgt = (vfpF == 0) ? 0 : vA1;
    endcase
    hs = mh < hsL;
    vs = mv < vsL;
    de = (mh >= hA0) && (mh < hA1) && (mv >= vA0) && (mv < vA1);
    vp = (mh == 0) && (mv == tgt);
    x = de ? mh - hA0 : 0;
    y = de ? mv - vA0 : 0;
    expQ.push_back({hs ^ invH, vs ^ invV, de ^ invD, vp, 10'(x), 10'(y)});
    mh++;
    if (mh == hT) begin
      mh = 0;
      mv = (mv == vT - 1) ? 0 : mv + 1;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!monOn) begin
      pend = 0;
      lastTick = -1;
    end else begin
      logic [23:0] e;
      cyc++;
      check(panelClk == (pixClkEn ^ invC), "R7 panelClk", panelClk, pixClkEn ^ invC);
      if (pend) begin
        e = expQ.pop_front();
        check(hsyncOut == e[23], "R4 hsync", hsyncOut, e[23]);
        check(vsyncOut == e[22], "R5 vsync", vsyncOut, e[22]);
        check(dataEnOut == e[21], "R6 dataEn", dataEnOut, e[21]);
        check(pixX == e[19:10], "R6 pixX", pixX, e[19:10]);
        check(lineY == e[9:0], "R6 lineY", lineY, e[9:0]);
        check(vcmpPulse == e[20], "R8 vcmpPulse", vcmpPulse, e[20]);
        pend = 0;
      end else begin
        check(vcmpPulse == 1'b0, "R8 pulse off-tick", vcmpPulse, 0);
      end
      if (pixClkEn) begin
        if (lastTick >= 0)
          check(cyc - lastTick == (byp ? 1 : pcd + 2), byp ? "R3 period" : "R2 period",
                cyc - lastTick, byp ? 1 : pcd + 2);
        lastTick = cyc;
        pushExpected();
        pend = 1;
        tickCnt++;
      end
    end
  end

  task automatic writeWord(int a, logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1; wrAddr = 2'(a); wrData = d;
    @(posedge clk); #1;
    wrEn = 0;
  endtask

  task automatic configure(int pp, int hs, int hb, int hf, int lp, int vs, int vb, int vf,
                           int pc, bit bp, bit iv, bit ih, bit ic, bit id, int sl);
    pplF = pp; hswF = hs; hbpF = hb; hfpF = hf; lppF = lp; vswF = vs; vbpF = vb;
    vfpF = vf; pcd = pc; byp = bp; invV = iv; invH = ih; invC = ic; invD = id; sel = sl;
    writeWord(0, (32'(pp) << 2) | (32'(hs) << 8) | (32'(hf) << 16) | (32'(hb) << 24));
    writeWord(1, 32'(lp) | (32'(vs) << 10) | (32'(vf) << 16) | (32'(vb) << 24));
    writeWord(2, (32'(pc) & 32'h1F) | (32'(iv) << 11) | (32'(ih) << 12) | (32'(ic) << 13) |
                 (32'(id) << 14) | (32'(bp) << 26) | ((32'(pc) >> 5) << 27));
    writeWord(3, 32'(sl));
  endtask

  task automatic startRun();
    @(posedge clk); #1;
    mh = 0; mv = 0; expQ.delete(); cyc = 0;
    monOn = 1; enable = 1;
  endtask

  task automatic stopRun();
    @(posedge clk); #1;
    monOn = 0; enable = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runTicks(int n);
    int target;
    target = tickCnt + n;
    while (tickCnt < target) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic checkIdle(string tag);
    check(pixClkEn == 0, {tag, " R10 pixClkEn"}, pixClkEn, 0);
    check(hsyncOut == invH, {tag, " R7 hsync idle"}, hsyncOut, invH);
    check(vsyncOut == invV, {tag, " R7 vsync idle"}, vsyncOut, invV);
    check(dataEnOut == invD, {tag, " R7 dataEn idle"}, dataEnOut, invD);
    check(panelClk == invC, {tag, " R7 panelClk idle"}, panelClk, invC);
    check(pixX == 0 && lineY == 0, {tag, " R10 coords"}, pixX + lineY, 0);
    check(vcmpPulse == 0, {tag, " R10 pulse"}, vcmpPulse, 0);
  endtask

  task automatic clearStatus();
    writeWord(3, 32'(sel) | 32'h100);
    @(negedge clk);
    check(vcmpStatus == 0, "R9 cleared", vcmpStatus, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1: reset state
    check(pixClkEn == 0, "R1 pixClkEn", pixClkEn, 0);
    check({hsyncOut, vsyncOut, dataEnOut, panelClk} == 0, "R1 sync levels",
          {hsyncOut, vsyncOut, dataEnOut, panelClk}, 0);
    check(pixX == 0 && lineY == 0, "R1 coords", pixX + lineY, 0);
    check(vcmpPulse == 0 && vcmpStatus == 0, "R1 interrupt", vcmpStatus, 0);

    // A: divided clock, porches on both axes, sync-start interrupt (23 x 8)
    configure(0, 1, 2, 1, 3, 0, 2, 1, 1, 0, 0, 0, 0, 0, 0);
    startRun();
    runTicks(2 * 184 + 5);
    stopRun();
    checkIdle("A");
    check(vcmpStatus == 1, "R9 sticky while off", vcmpStatus, 1);
    clearStatus();

    // B: bypass with junk divisor, all inverted, zero vertical porches, phase 3
    configure(0, 0, 0, 0, 1, 1, 0, 0, 10'h3FF, 1, 1, 1, 1, 1, 3);
    startRun();
    runTicks(2 * 76 + 3);
    stopRun();
    checkIdle("B");
    check(vcmpStatus == 1, "R8 folded front-porch phase fired", vcmpStatus, 1);
    clearStatus();

    // C: split divisor 33 (both halves non-zero), back-porch phase
    configure(0, 1, 2, 1, 1, 0, 2, 2, 33, 0, 0, 0, 0, 0, 1);
    startRun();
    runTicks(161 + 30);
    stopRun();
    checkIdle("C");
    check(vcmpStatus == 1, "R9 set by back porch phase", vcmpStatus, 1);
    clearStatus();

    // D: fastest divider, inverted data enable only, active-start phase
    configure(0, 1, 2, 1, 3, 0, 2, 1, 0, 0, 0, 0, 0, 1, 2);
    startRun();
    runTicks(184 + 40);
    stopRun();
    checkIdle("D");
    check(vcmpStatus == 1, "R8 active phase fired", vcmpStatus, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule